// File: doc/BRIEF.md
# Ethernet PHY Management Register File

This block holds the management registers of a 10/100 Ethernet PHY as a MAC-side controller sees them through a simple read/write port. Each access carries an 8-bit PHY address and an 8-bit register index. A neighbouring target register supplies both fields, packed as two 8-bit fields at fixed shifts. A write also carries 16-bit data. Only accesses whose address matches the configured PHY address reach the registers.

Four registers are stored: basic control, basic status, local advertisement and link-partner ability. Two constant identifier words can also be read. A link-up input is synchronised inside the block. On each change of that input, the link-status and negotiation-complete bits and the partner-ability word are rewritten. A control write with bit 15 set is not stored. It restores every register to its reset value and then applies the current link level.

The bit-level serial management framing is not part of this block. Vendor registers are not implemented and read as zero.

Top module: `mii_mgmt_regs`

## Requirements
- R1: After the synchronous reset, the registers read as follows. Control (index 0) reads 0x3100: bit 13 speed 100, bit 12 auto-negotiation enable, bit 8 full duplex. Status (index 1) reads 0x7848: bits 14, 13, 12 and 11 for the capabilities, bit 6 preamble suppression, bit 3 negotiation-able. Advertisement (index 4) reads 0x01E1. Partner ability (index 5) reads 0x0080. If link_up_i is high, the link level is applied afterwards as in R2.
- R2: When the synchronised link level goes high, the block sets status bits 2 (link) and 5 (negotiation complete) and ORs 0x0161 into the partner word. The new values take effect on the SYNC_STAGES+1-th rising edge after link_up_i changes. A read whose rd_en_i is sampled on that edge or earlier still returns the old value.
- R3: When the link level goes low, the block clears status bits 2 and 5 and sets the partner word back to 0x0080.
- R4: A read returns its data on rd_data_o at the rising edge that samples rd_en_i. rd_data_o keeps that value while no read is issued.
- R5: A read whose 8-bit phy_addr_i differs from the zero-extended 5-bit PHY_ADDR returns 0xFFFF.
- R6: A write whose phy_addr_i does not match has no effect, including a write of the reset bit.
- R7: A matching write to index 0 with bit 15 set restores all reset values and applies the current link level. Any other write to index 0 stores the data as given.
- R8: A matching write to index 4 stores the data as given.
- R9: Writes to index 1, 2, 3, 5 and 6 have no effect.
- R10: A read of any index from 6 to 255 returns 0x0000.
- R11: Index 2 reads the parameter ID_HI and index 3 reads the parameter ID_LO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| phy_addr_i | input | 8 | PHY address of the access |
| reg_idx_i | input | 8 | Register index of the access |
| wr_data_i | input | 16 | Write data |
| wr_en_i | input | 1 | Write strobe, one cycle per write |
| rd_en_i | input | 1 | Read strobe, one cycle per read |
| link_up_i | input | 1 | Asynchronous link-up level |
| rd_data_o | output | 16 | Registered read data |

## Verification
A read is due on rd_data_o right after the edge that samples rd_en_i. The bench therefore raises a strobe at a falling edge and samples the output at the next falling edge. A write changes the stored value on its edge, so the read that follows in the next cycle must already show it. A link change lands SYNC_STAGES+1 edges after the input moves. The bench pins this latency down with back-to-back reads: the first two reads still return the old status word and the third returns the new one.

// File: rtl/mii_mgmt_pkg.sv
package mii_mgmt_pkg;
  localparam int IDX_W  = 8;
  localparam int DATA_W = 16;

  localparam logic [IDX_W-1:0] IDX_CTRL = 8'd0;
  localparam logic [IDX_W-1:0] IDX_STAT = 8'd1;
  localparam logic [IDX_W-1:0] IDX_IDH  = 8'd2;
  localparam logic [IDX_W-1:0] IDX_IDL  = 8'd3;
  localparam logic [IDX_W-1:0] IDX_ADV  = 8'd4;
  localparam logic [IDX_W-1:0] IDX_LPA  = 8'd5;

  localparam int SOFT_RST_BIT = 15;

  localparam logic [DATA_W-1:0] CTRL_DEF      = 16'h3100;
  localparam logic [DATA_W-1:0] STAT_DEF      = 16'h7848;
  localparam logic [DATA_W-1:0] ADV_DEF       = 16'h01E1;
  localparam logic [DATA_W-1:0] LPA_DOWN      = 16'h0080;
  localparam logic [DATA_W-1:0] LPA_UP_BITS   = 16'h0161;
  localparam logic [DATA_W-1:0] STAT_UP_BITS  = 16'h0024;
  localparam logic [DATA_W-1:0] FOREIGN_READ  = 16'hFFFF;

  function automatic logic [DATA_W-1:0] status_for_link(
      input logic [DATA_W-1:0] cur, input logic up);
    return up ? (cur | STAT_UP_BITS) : (cur & ~STAT_UP_BITS);
  endfunction

  function automatic logic [DATA_W-1:0] partner_for_link(
      input logic [DATA_W-1:0] cur, input logic up);
    return up ? (cur | LPA_UP_BITS) : LPA_DOWN;
  endfunction
endpackage

// File: rtl/mii_link_sync.sv
module mii_link_sync #(
  parameter int STAGES = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic link_in,
  output logic link_lvl,
  output logic link_chg
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= link_in;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= {chain_q[STAGES-2:0], link_in};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= chain_q[STAGES-1];
  end

  assign link_lvl = chain_q[STAGES-1];
  assign link_chg = chain_q[STAGES-1] ^ prev_q;
endmodule

// File: rtl/mii_reg_core.sv
module mii_reg_core
  import mii_mgmt_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_hit,
  input  logic [IDX_W-1:0]  reg_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              link_lvl,
  input  logic              link_chg,
  output logic [DATA_W-1:0] ctrl_q,
  output logic [DATA_W-1:0] stat_q,
  output logic [DATA_W-1:0] adv_q,
  output logic [DATA_W-1:0] lpa_q
);
  logic ctrl_wr, adv_wr, soft_rst;

  assign ctrl_wr  = wr_hit && (reg_idx == IDX_CTRL);
  assign adv_wr   = wr_hit && (reg_idx == IDX_ADV);
  assign soft_rst = ctrl_wr && wr_data[SOFT_RST_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= CTRL_DEF;
      stat_q <= STAT_DEF;
      adv_q  <= ADV_DEF;
      lpa_q  <= LPA_DOWN;
    end else if (soft_rst) begin
      ctrl_q <= CTRL_DEF;
      adv_q  <= ADV_DEF;
      stat_q <= status_for_link(STAT_DEF, link_lvl);
      lpa_q  <= partner_for_link(LPA_DOWN, link_lvl);
    end else begin
      if (ctrl_wr) ctrl_q <= wr_data;
      if (adv_wr)  adv_q  <= wr_data;
      if (link_chg) begin
        stat_q <= status_for_link(stat_q, link_lvl);
        lpa_q  <= partner_for_link(lpa_q, link_lvl);
      end
    end
  end
endmodule

// File: rtl/mii_read_port.sv
module mii_read_port
  import mii_mgmt_pkg::*;
#(
  parameter logic [DATA_W-1:0] ID_HI = 16'h0243,
  parameter logic [DATA_W-1:0] ID_LO = 16'h0C54
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic              addr_hit,
  input  logic [IDX_W-1:0]  reg_idx,
  input  logic [DATA_W-1:0] ctrl_q,
  input  logic [DATA_W-1:0] stat_q,
  input  logic [DATA_W-1:0] adv_q,
  input  logic [DATA_W-1:0] lpa_q,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] sel;

  always_comb begin
    case (reg_idx)
      IDX_CTRL: sel = ctrl_q;
      IDX_STAT: sel = stat_q;
      IDX_IDH:  sel = ID_HI;
      IDX_IDL:  sel = ID_LO;
      IDX_ADV:  sel = adv_q;
      IDX_LPA:  sel = lpa_q;
      default:  sel = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= addr_hit ? sel : FOREIGN_READ;
  end
endmodule

// File: rtl/mii_mgmt_regs.sv
module mii_mgmt_regs
  import mii_mgmt_pkg::*;
#(
  parameter logic [4:0]        PHY_ADDR    = 5'd0,
  parameter logic [DATA_W-1:0] ID_HI       = 16'h0243,
  parameter logic [DATA_W-1:0] ID_LO       = 16'h0C54,
  parameter int                SYNC_STAGES = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IDX_W-1:0]  phy_addr_i,
  input  logic [IDX_W-1:0]  reg_idx_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic              link_up_i,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam logic [IDX_W-1:0] OWN_ADDR = {{(IDX_W-5){1'b0}}, PHY_ADDR};

  logic              addr_hit;
  logic              link_lvl, link_chg;
  logic [DATA_W-1:0] ctrl_q, stat_q, adv_q, lpa_q;

  assign addr_hit = (phy_addr_i == OWN_ADDR);

  mii_link_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .link_in  (link_up_i),
    .link_lvl (link_lvl),
    .link_chg (link_chg)
  );

  mii_reg_core u_core (
    .clk      (clk),
    .rst      (rst),
    .wr_hit   (wr_en_i && addr_hit),
    .reg_idx  (reg_idx_i),
    .wr_data  (wr_data_i),
    .link_lvl (link_lvl),
    .link_chg (link_chg),
    .ctrl_q   (ctrl_q),
    .stat_q   (stat_q),
    .adv_q    (adv_q),
    .lpa_q    (lpa_q)
  );

  mii_read_port #(.ID_HI(ID_HI), .ID_LO(ID_LO)) u_rd (
    .clk      (clk),
    .rst      (rst),
    .rd_en    (rd_en_i),
    .addr_hit (addr_hit),
    .reg_idx  (reg_idx_i),
    .ctrl_q   (ctrl_q),
    .stat_q   (stat_q),
    .adv_q    (adv_q),
    .lpa_q    (lpa_q),
    .rd_data  (rd_data_o)
  );
endmodule

// File: rtl/mii_mgmt_chk.sv
module mii_mgmt_chk #(
  parameter logic [4:0] PHY_ADDR = 5'd0
) (
  input logic        clk,
  input logic        rst,
  input logic [7:0]  phy_addr_i,
  input logic [7:0]  reg_idx_i,
  input logic [15:0] wr_data_i,
  input logic        wr_en_i,
  input logic        rd_en_i,
  input logic [15:0] rd_data_o,
  input logic [15:0] ctrl_q,
  input logic [15:0] stat_q,
  input logic [15:0] adv_q,
  input logic [15:0] lpa_q
);
  logic hit;
  assign hit = (phy_addr_i == {3'b000, PHY_ADDR});

  AST_RESET_DEFAULTS: assert property (@(posedge clk)
    rst |=> (ctrl_q == 16'h3100 && adv_q == 16'h01E1 &&
             stat_q == 16'h7848 && lpa_q == 16'h0080)); // R1
  AST_LINK_PAIR: assert property (@(posedge clk) disable iff (rst)
    stat_q[2] == stat_q[5]); // R2
  AST_PARTNER_TRACKS: assert property (@(posedge clk) disable iff (rst)
    stat_q[2] ? (lpa_q == 16'h01E1) : (lpa_q == 16'h0080)); // R3
  AST_READ_HOLD: assert property (@(posedge clk) disable iff (rst)
    !rd_en_i |=> $stable(rd_data_o)); // R4
  AST_FOREIGN_READ: assert property (@(posedge clk) disable iff (rst)
    (rd_en_i && !hit) |=> rd_data_o == 16'hFFFF); // R5
  AST_FOREIGN_WRITE: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && !hit) |=> ($stable(ctrl_q) && $stable(adv_q))); // R6
  AST_SOFT_RESET: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && hit && reg_idx_i == 8'd0 && wr_data_i[15])
      |=> (ctrl_q == 16'h3100 && adv_q == 16'h01E1)); // R7
  AST_CTRL_STORE: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && hit && reg_idx_i == 8'd0 && !wr_data_i[15])
      |=> ctrl_q == $past(wr_data_i)); // R7
  AST_ADV_STORE: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && hit && reg_idx_i == 8'd4) |=> adv_q == $past(wr_data_i)); // R8
  AST_UNKNOWN_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_en_i && hit && reg_idx_i > 8'd5) |=> rd_data_o == 16'h0000); // R10
endmodule

bind mii_mgmt_regs mii_mgmt_chk #(.PHY_ADDR(PHY_ADDR)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .phy_addr_i (phy_addr_i),
  .reg_idx_i  (reg_idx_i),
  .wr_data_i  (wr_data_i),
  .wr_en_i    (wr_en_i),
  .rd_en_i    (rd_en_i),
  .rd_data_o  (rd_data_o),
  .ctrl_q     (ctrl_q),
  .stat_q     (stat_q),
  .adv_q      (adv_q),
  .lpa_q      (lpa_q)
);

// File: tb/sim_mii_mgmt_regs.sv
module sim_mii_mgmt_regs;
  localparam logic [15:0] B_ID_HI = 16'hA5C3;
  localparam logic [15:0] B_ID_LO = 16'h5A3C;
  localparam int NV = 22;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  phy_addr_i = '0;
  logic [7:0]  reg_idx_i = '0;
  logic [15:0] wr_data_i = '0;
  logic        wr_en_i = 1'b0;
  logic        rd_en_i = 1'b0;
  logic        link_up_i = 1'b0;
  logic [15:0] rd_data_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  mii_mgmt_regs #(.PHY_ADDR(5'd0), .ID_HI(B_ID_HI), .ID_LO(B_ID_LO),
                  .SYNC_STAGES(1)) u0 (
    .clk(clk), .rst(rst), .phy_addr_i(phy_addr_i), .reg_idx_i(reg_idx_i),
    .wr_data_i(wr_data_i), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i),
    .link_up_i(link_up_i), .rd_data_o(rd_data_o)
  );

  // {is_read, req, addr, index, wdata, expected}
  localparam logic [52:0] VEC [NV] = '{
    {1'b0, 4'd9,  8'h00, 8'h01, 16'hFFFF, 16'h0000}, // R9 status write
    {1'b1, 4'd9,  8'h00, 8'h01, 16'h0000, 16'h7848}, // R9
    {1'b0, 4'd9,  8'h00, 8'h02, 16'h0000, 16'h0000}, // R9 id write
    {1'b1, 4'd11, 8'h00, 8'h02, 16'h0000, B_ID_HI},  // R11
    {1'b1, 4'd11, 8'h00, 8'h03, 16'h0000, B_ID_LO},  // R11
    {1'b0, 4'd9,  8'h00, 8'h05, 16'hFFFF, 16'h0000}, // R9 partner write
    {1'b1, 4'd9,  8'h00, 8'h05, 16'h0000, 16'h0080}, // R9
    {1'b0, 4'd9,  8'h00, 8'h06, 16'h1234, 16'h0000}, // R9 expansion write
    {1'b1, 4'd10, 8'h00, 8'h06, 16'h0000, 16'h0000}, // R10
    {1'b1, 4'd10, 8'h00, 8'h1F, 16'h0000, 16'h0000}, // R10
    {1'b1, 4'd10, 8'h00, 8'hFF, 16'h0000, 16'h0000}, // R10
    {1'b1, 4'd5,  8'h01, 8'h00, 16'h0000, 16'hFFFF}, // R5
    {1'b1, 4'd5,  8'h20, 8'h00, 16'h0000, 16'hFFFF}, // R5 upper address bits
    {1'b0, 4'd6,  8'h01, 8'h04, 16'h0001, 16'h0000}, // R6
    {1'b1, 4'd6,  8'h00, 8'h04, 16'h0000, 16'h01E1}, // R6
    {1'b0, 4'd8,  8'h00, 8'h04, 16'h0021, 16'h0000}, // R8
    {1'b1, 4'd8,  8'h00, 8'h04, 16'h0000, 16'h0021}, // R8
    {1'b0, 4'd7,  8'h00, 8'h00, 16'h2000, 16'h0000}, // R7 plain store
    {1'b1, 4'd7,  8'h00, 8'h00, 16'h0000, 16'h2000}, // R7
    {1'b0, 4'd6,  8'h03, 8'h00, 16'h8000, 16'h0000}, // R6 foreign reset bit
    {1'b1, 4'd6,  8'h00, 8'h00, 16'h0000, 16'h2000}, // R6
    {1'b1, 4'd10, 8'h00, 8'h07, 16'h0000, 16'h0000}  // R10
  };

  task automatic check(input string what, input logic [15:0] got,
                       input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", what, got, exp);
    end
  endtask

  task automatic do_write(input logic [7:0] a, input logic [7:0] r,
                          input logic [15:0] d);
    @(negedge clk);
    phy_addr_i = a; reg_idx_i = r; wr_data_i = d; wr_en_i = 1'b1;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic do_read(input logic [7:0] a, input logic [7:0] r,
                         output logic [15:0] got);
    @(negedge clk);
    phy_addr_i = a; reg_idx_i = r; rd_en_i = 1'b1;
    @(negedge clk);
    rd_en_i = 1'b0;
    got = rd_data_o;
  endtask

  task automatic read_check(input logic [7:0] r, input logic [15:0] exp,
                            input string what);
    logic [15:0] got;
    do_read(8'h00, r, got);
    check(what, got, exp);
  endtask

  initial begin
    logic [15:0] got;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R4 rd_data after reset", rd_data_o, 16'h0000);
    read_check(8'd0, 16'h3100, "R1 control default");
    read_check(8'd1, 16'h7848, "R1 status default");
    read_check(8'd4, 16'h01E1, "R1 advert default");
    read_check(8'd5, 16'h0080, "R1 partner default");
    repeat (2) @(negedge clk);
    check("R4 read data held", rd_data_o, 16'h0080);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][52]) begin
        do_read(VEC[i][47:40], VEC[i][39:32], got);
        check($sformatf("R%0d vector %0d", VEC[i][51:48], i), got,
              VEC[i][15:0]);
      end else begin
        do_write(VEC[i][47:40], VEC[i][39:32], VEC[i][31:16]);
      end
    end

    // R2 latency: the link change lands on the second edge after the input moves
    @(negedge clk);
    link_up_i = 1'b1;
    phy_addr_i = 8'h00; reg_idx_i = 8'd1; rd_en_i = 1'b1;
    @(negedge clk);
    check("R2 status at edge 1", rd_data_o, 16'h7848);
    @(negedge clk);
    check("R2 status at edge 2", rd_data_o, 16'h7848);
    @(negedge clk);
    rd_en_i = 1'b0;
    check("R2 status at edge 3", rd_data_o, 16'h786C);
    read_check(8'd5, 16'h01E1, "R2 partner link up");

    // R7 soft reset with link up
    do_write(8'h00, 8'd0, 16'h8000);
    read_check(8'd0, 16'h3100, "R7 soft reset control");
    read_check(8'd4, 16'h01E1, "R7 soft reset advert");
    read_check(8'd1, 16'h786C, "R7 soft reset status link up");
    read_check(8'd5, 16'h01E1, "R7 soft reset partner link up");

    // R3 link down
    @(negedge clk);
    link_up_i = 1'b0;
    repeat (3) @(negedge clk);
    read_check(8'd1, 16'h7848, "R3 status link down");
    read_check(8'd5, 16'h0080, "R3 partner link down");

    // R1 reset with link already up
    @(negedge clk);
    link_up_i = 1'b1; rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    read_check(8'd1, 16'h786C, "R1 link applied after reset");
    read_check(8'd5, 16'h01E1, "R1 partner after reset");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule